// File: doc/BRIEF.md
# FFT Two-Real-Channel Separation Stage

A complex FFT can transform two real signals at once when one is placed in the real part of its input and the other in the imaginary part. The resulting spectrum mixes both channels. This stage sits after such an FFT and recovers one bin of each channel from every pair of neighbouring complex samples. The bins are assumed to arrive already reordered so that each pair holds the two bins that combine.

Samples arrive one per cycle while `in_valid` is high, and gaps in `in_valid` are allowed. The stage treats the accepted samples as consecutive pairs. When the second sample of a pair is accepted, it forms the channel A bin and the channel B bin. Each is computed with one extra bit of headroom and then halved. The stage then emits A and B on one output stream on two consecutive cycles. The number of output words equals the number of input words. The stage has no flow control.

Top module: `fft_pair_splitter`

## Requirements
- R1: While reset is high, and after reset until the first output, `out_valid` is 0 and `out_word` is all zeros. Reset is synchronous and active high. After reset, the next accepted sample counts as the first of a pair.
- R2: Each word holds two 16-bit two's-complement parts, with the imaginary part in bits 31:16 and the real part in bits 15:0. Input and output words use the same layout.
- R3: The pair position advances only on cycles with `in_valid` high. Idle cycles between or within pairs do not change which sample is first or second. No output is produced before the second sample of a pair is accepted.
- R4: With first sample (r0,i0) and second sample (r1,i1), the real part of output A is bits 16:1 of the 17-bit sum r1+r0.
- R5: The imaginary part of output A is bits 16:1 of the 17-bit difference i0−i1.
- R6: The real part of output B is bits 16:1 of the 17-bit sum i1+i0.
- R7: The imaginary part of output B is bits 16:1 of the 17-bit difference r1−r0.
- R8: Output A is presented with `out_valid` high in the cycle after the clock edge that accepts the second sample. Output B follows in the next cycle. `out_valid` is high in exactly those two cycles per pair, so pairs presented back to back give an unbroken stream A,B,A,B.
- R9: Halving drops the least significant bit without rounding, so odd negative results go toward minus infinity (for example −1 becomes −1 and −9 becomes −5). Full-scale operands never overflow: 32767+32767 gives 32767, and −32768−32767 gives −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_word | input | 32 | Packed complex input {imag, real} |
| out_valid | output | 1 | Output sample strobe |
| out_word | output | 32 | Packed complex output {imag, real}, A then B |

## Verification
The hardest case to reach is a pair whose two samples are split by idle cycles, followed by a pair arriving immediately after. That second pair must not disturb the pending B output, and both pairs must keep their pairing. The stimulus covers this in two ways. Directed runs insert fixed gaps inside a pair. A long random run drops `in_valid` about half the time, which produces both split pairs and back-to-back A,B,A,B streams. A behavioural model in the bench checks both the strobe and the data every cycle. Directed full-scale and odd-negative operands test the headroom and the rounding toward minus infinity.

// File: rtl/fft_split_pkg.sv
package fft_split_pkg;

    localparam int PART_W = 16;
    localparam int WORD_W = 2 * PART_W;
    localparam int WIDE_W = PART_W + 1;

    typedef logic signed [PART_W-1:0] part_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    // Packed so that the imaginary part sits in the upper half of the word.
    typedef struct packed {
        part_t im;
        part_t re;
    } cplx_t;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;

    function automatic part_t halve(input wide_t v);
        return v[WIDE_W-1:1];
    endfunction

    function automatic part_t half_add(input part_t a, input part_t b);
        wide_t s;
        s = {a[PART_W-1], a} + {b[PART_W-1], b};
        return halve(s);
    endfunction

    function automatic part_t half_sub(input part_t a, input part_t b);
        wide_t d;
        d = {a[PART_W-1], a} - {b[PART_W-1], b};
        return halve(d);
    endfunction

endpackage

// File: rtl/fft_split_pair.sv
module fft_split_pair
    import fft_split_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  cplx_t in_word,
    output logic  pair_fire,
    output cplx_t first_q
);

    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= SLOT_FIRST;
            first_q <= '0;
        end else if (in_valid) begin
            if (slot_q == SLOT_FIRST) begin
                first_q <= in_word;
                slot_q  <= SLOT_SECOND;
            end else begin
                slot_q  <= SLOT_FIRST;
            end
        end
    end

    assign pair_fire = in_valid && (slot_q == SLOT_SECOND);

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(slot_q)); // R3
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (slot_q != $past(slot_q))); // R3

endmodule

// File: rtl/fft_split_butterfly.sv
module fft_split_butterfly
    import fft_split_pkg::*;
(
    input  cplx_t first_s,
    input  cplx_t second_s,
    output cplx_t bin_a,
    output cplx_t bin_b
);

    always_comb begin
        bin_a.re = half_add(second_s.re, first_s.re);
        bin_a.im = half_sub(first_s.im, second_s.im);
        bin_b.re = half_add(second_s.im, first_s.im);
        bin_b.im = half_sub(second_s.re, first_s.re);
    end

endmodule

// File: rtl/fft_split_emit.sv
module fft_split_emit
    import fft_split_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  cplx_t bin_a,
    input  cplx_t bin_b,
    output cplx_t out_q,
    output logic  out_valid
);

    logic  pend_q;
    cplx_t b_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            b_hold_q  <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else if (fire) begin
            out_q     <= bin_a;
            b_hold_q  <= bin_b;
            pend_q    <= 1'b1;
            out_valid <= 1'b1;
        end else if (pend_q) begin
            out_q     <= b_hold_q;
            pend_q    <= 1'b0;
            out_valid <= 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        fire |-> !pend_q); // R8
    AST_A_THEN_PEND: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_valid && pend_q)); // R8

endmodule

// File: rtl/fft_pair_splitter.sv
module fft_pair_splitter
    import fft_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    cplx_t in_c;
    cplx_t first_c;
    cplx_t bin_a;
    cplx_t bin_b;
    cplx_t out_c;
    logic  fire;

    assign in_c = cplx_t'(in_word);

    fft_split_pair u_pair (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_c),
        .pair_fire (fire),
        .first_q   (first_c)
    );

    fft_split_butterfly u_bfly (
        .first_s  (first_c),
        .second_s (in_c),
        .bin_a    (bin_a),
        .bin_b    (bin_b)
    );

    fft_split_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .bin_a     (bin_a),
        .bin_b     (bin_b),
        .out_q     (out_c),
        .out_valid (out_valid)
    );

    assign out_word = out_c;

    AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |=> out_valid); // R8
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(out_valid)) |-> !out_valid); // R3

endmodule

// File: tb/fft_pair_splitter_test.sv
module fft_pair_splitter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    always #4 clk = ~clk;

    fft_pair_splitter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic int half(input int v);
        return v >>> 1;
    endfunction

    function automatic logic [31:0] pack(input int re, input int im);
        logic [31:0] w;
        w[15:0]  = re[15:0];
        w[31:16] = im[15:0];
        return w;
    endfunction

    function automatic int lo(input logic [31:0] w);
        return int'($signed(w[15:0]));
    endfunction

    function automatic int hi(input logic [31:0] w);
        return int'($signed(w[31:16]));
    endfunction

    // Behavioural reference model, updated on each rising edge.
    bit          m_second = 1'b0;
    int          m_r0 = 0, m_i0 = 0;
    bit          m_val = 1'b0;
    bit          m_is_a = 1'b0;
    logic [31:0] m_dat = '0;
    bit          m_pend = 1'b0;
    logic [31:0] m_b = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_second <= 1'b0; m_val <= 1'b0; m_pend <= 1'b0;
            m_dat <= '0; m_is_a <= 1'b0;
        end else begin
            if (m_pend) begin
                m_val <= 1'b1; m_dat <= m_b; m_pend <= 1'b0; m_is_a <= 1'b0;
            end else begin
                m_val <= 1'b0;
            end
            if (in_valid) begin
                if (!m_second) begin
                    m_r0 <= lo(in_word); m_i0 <= hi(in_word);
                end else begin
                    m_dat  <= pack(half(lo(in_word) + m_r0), half(m_i0 - hi(in_word)));
                    m_b    <= pack(half(hi(in_word) + m_i0), half(lo(in_word) - m_r0));
                    m_val  <= 1'b1; m_pend <= 1'b1; m_is_a <= 1'b1;
                end
                m_second <= !m_second;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            checks++;
            if (out_valid !== m_val) begin
                errors++;
                $display("FAIL R8 R3: out_valid actual=%0b expected=%0b", out_valid, m_val);
            end
            if (m_val) begin
                checks++;
                if (out_word !== m_dat) begin
                    errors++;
                    if (m_is_a)
                        $display("FAIL R4 R5: A actual=%h expected=%h", out_word, m_dat);
                    else
                        $display("FAIL R6 R7: B actual=%h expected=%h", out_word, m_dat);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input int re, input int im);
        in_valid = 1'b1;
        in_word  = pack(re, im);
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = $urandom;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Drive a pair with a gap between the two samples; then check A, B, and idle.
    task automatic pair_check(input string tag, input int r0, input int i0,
                              input int r1, input int i1, input int gap,
                              input int ear, input int eai, input int ebr, input int ebi);
        drive(r0, i0);
        for (int k = 0; k < gap; k++) begin
            check("R3 gap", {out_valid, 32'h0}, {1'b0, 32'h0});
            @(negedge clk);
        end
        drive(r1, i1);
        check({tag, " R4 R5 R8 A"}, {out_valid, out_word}, {1'b1, pack(ear, eai)});
        @(negedge clk);
        check({tag, " R6 R7 R8 B"}, {out_valid, out_word}, {1'b1, pack(ebr, ebi)});
        @(negedge clk);
        check({tag, " R8 idle"}, {out_valid, 32'h0}, {1'b0, 32'h0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        check("R1 reset", {out_valid, out_word}, 33'h0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 after reset", {out_valid, out_word}, 33'h0);
        idle(2);
        check("R1 idle", {out_valid, out_word}, 33'h0);

        // R2 packing, R4..R7 arithmetic
        pair_check("R2", 5, -3, 8, 6, 0, 6, -5, 1, 1);
        // R3 pairing survives gaps
        pair_check("R3", 100, 40, -20, 10, 3, 40, 15, 25, -60);
        // R9 full scale and rounding toward minus infinity
        pair_check("R9", 32767, -32768, 32767, 32767, 0, 32767, -32768, -1, 0);
        pair_check("R9", -32768, 32767, 32767, 32767, 1, -1, 0, 32767, 32767);
        pair_check("R9", -32768, -32768, -32768, -32768, 0, -32768, 0, -32768, 0);
        pair_check("R9", -1, 0, -2, 1, 0, -2, -1, 0, -1);

        // Random traffic with the model compared every cycle
        mon_en = 1'b1;
        for (int n = 0; n < 600; n++) begin
            in_valid = ($urandom % 2) == 0;
            in_word  = $urandom;
            @(negedge clk);
        end
        in_valid = 1'b1;
        for (int n = 0; n < 64; n++) begin
            in_word = $urandom;
            @(negedge clk);
        end
        in_valid = 1'b0;
        idle(6);
        finish_run();
    end

endmodule